// File: doc/BRIEF.md
# External Interrupt Pin Decoder

This block turns eight active-low interrupt pins and one active-low non-maskable pin into registered interrupt requests for a processor core. Every pin is synchronized before use. A two-bit mode input chooses how the eight pins are read. In dedicated mode each pin is its own source. In expanded mode the pins together carry an inverted 8-bit vector number. In mixed mode the upper three pins are dedicated sources and the lower five pins carry the upper bits of a vector.

In dedicated mode each source can be set to low-level or falling-edge sensitivity, and it can be enabled on its own. The block reports a pending bit for each source and the highest-numbered pending source. It also reports a vectored request with its number and a non-maskable pending flag. The core retires edge-latched sources and the non-maskable request through acknowledge strobes. A non-maskable request outranks everything else and hides the other request flags while it is pending.

Top module: `extIrqDecoder`

## Requirements
- R1: After reset every output is 0.
- R2: A pin change reaches the outputs on the third rising clock edge after it is applied, and not before. A level-sensitive dedicated source (edgeSel bit 0) with its enable bit set reads pending while its pin is low and clears when the pin returns high.
- R3: A falling edge on an enabled edge-sensitive dedicated source (edgeSel bit 1) sets its srcPending bit. The bit stays set after the pin returns high, and an ackSrc bit held for one rising edge clears it at that edge.
- R4: With its srcEnable bit 0, a source never reads pending. An edge that arrives while the source is disabled is discarded and does not show up when the source is enabled later.
- R5: topValid is 1 when any srcPending bit is set and no non-maskable request is pending. topSrc gives the highest index among the set bits, and it is 0 when no bit is set.
- R6: In expanded mode (modeSel 1), vecNum is the bitwise inverse of the synchronized pins and srcPending is 0. When all pins are high, vecValid and vecNum are 0.
- R7: In mixed mode (modeSel 2), pins 7 to 5 are dedicated sources and srcPending bits 4 to 0 read 0. vecNum is the inverse of pins 4 to 0 in bits 7 to 3, with bits 2 to 0 fixed at binary 010. When pins 4 to 0 are all high, vecValid and vecNum are 0.
- R8: A falling edge on nmiN sets nmiPending, which stays set until ackNmi is held for one rising edge. Holding nmiN low does not set it again.
- R9: While nmiPending is 1, topValid and vecValid are 0, and topSrc, vecNum and srcPending still show their decoded values.
- R10: A latched edge request is dropped at the next rising edge when its source stops being an enabled edge-sensitive dedicated source, for example on a switch to expanded mode. Switching back does not restore it.
- R11: modeSel 3 behaves as dedicated mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| pinN | input | 8 | External interrupt pins, active low, asynchronous |
| nmiN | input | 1 | Non-maskable interrupt pin, active low, asynchronous |
| modeSel | input | 2 | 0 dedicated, 1 expanded, 2 mixed, 3 dedicated |
| edgeSel | input | 8 | Per source: 1 falling edge, 0 low level |
| srcEnable | input | 8 | Per source enable for dedicated sources |
| ackSrc | input | 8 | Clears latched edge requests, one bit per source |
| ackNmi | input | 1 | Clears the non-maskable pending flag |
| srcPending | output | 8 | Pending bit per dedicated source |
| topValid | output | 1 | At least one dedicated source is pending and no NMI is pending |
| topSrc | output | 3 | Highest pending source index |
| vecValid | output | 1 | A vectored request is present and no NMI is pending |
| vecNum | output | 8 | Vector number of the vectored request |
| nmiPending | output | 1 | Non-maskable request pending |

## Verification
On every cycle the assertions check several properties. topSrc must name the highest set pending bit. No request flag may be raised under a pending non-maskable request. A vectored request can never carry vector 0, and the fixed low vector bits must hold in mixed mode. Expanded mode must leave srcPending clear. Latched bits must fall only on an acknowledge or a mask change. Only the bench scenarios can show the timing: the exact three-edge latency from pin to output, the inversion of pin patterns into vector numbers, disabled edges being discarded, and level NMI holding not retriggering.

// File: rtl/extIrqPkg.sv
package extIrqPkg;

  localparam int unsigned PIN_CNT = 8;

  typedef enum logic [1:0] {
    MODE_DEDICATED = 2'd0,
    MODE_EXPANDED  = 2'd1,
    MODE_MIXED     = 2'd2,
    MODE_SPARE     = 2'd3
  } pinMode_e;

  typedef enum logic [1:0] {
    VEC_OFF   = 2'd0,
    VEC_FULL  = 2'd1,
    VEC_SPLIT = 2'd2
  } vecSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [PIN_CNT-1:0] dedMask;   // enabled dedicated sources
    logic [PIN_CNT-1:0] edgeMask;  // enabled dedicated edge sources
    logic [PIN_CNT-1:0] latchClr;  // acknowledge per source
    logic               nmiClr;
    vecSel_e            vecSel;
  } ctrlStrb_t;

endpackage

// File: rtl/extIrqSync.sv
module extIrqSync #(
  parameter int unsigned WIDTH  = 9,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageQ <= '1;
    end else begin
      for (int s = STAGES - 1; s > 0; s--) begin
        stageQ[s] <= stageQ[s-1];
      end
      stageQ[0] <= din;
    end
  end

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/extIrqCtrl.sv
module extIrqCtrl
  import extIrqPkg::*;
#(
  parameter int unsigned MIX_DED = 3
) (
  input  logic [1:0]         modeSel,
  input  logic [PIN_CNT-1:0] edgeSel,
  input  logic [PIN_CNT-1:0] srcEnable,
  input  logic [PIN_CNT-1:0] ackSrc,
  input  logic               ackNmi,
  output ctrlStrb_t          strb
);

  localparam logic [PIN_CNT-1:0] SPLIT_MASK = {PIN_CNT{1'b1}} << (PIN_CNT - MIX_DED);

  logic [PIN_CNT-1:0] dedAll;
  vecSel_e            vecSel;

  always_comb begin
    case (pinMode_e'(modeSel))
      MODE_EXPANDED: begin
        dedAll = '0;
        vecSel = VEC_FULL;
      end
      MODE_MIXED: begin
        dedAll = SPLIT_MASK;
        vecSel = VEC_SPLIT;
      end
      default: begin
        dedAll = '1;
        vecSel = VEC_OFF;
      end
    endcase
  end

  always_comb begin
    strb.dedMask  = dedAll & srcEnable;
    strb.edgeMask = dedAll & srcEnable & edgeSel;
    strb.latchClr = ackSrc;
    strb.nmiClr   = ackNmi;
    strb.vecSel   = vecSel;
  end

endmodule

// File: rtl/extIrqPrio.sv
module extIrqPrio #(
  parameter int unsigned N     = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             anyReq,
  output logic [IDX_W-1:0] topIdx
);

  always_comb begin
    topIdx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) topIdx = IDX_W'(i);
    end
  end

  assign anyReq = |req;

endmodule

// File: rtl/extIrqDatapath.sv
module extIrqDatapath
  import extIrqPkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIX_DED     = 3,
  parameter logic [MIX_DED-1:0] MIX_LOW_PAT = 3'b010,
  localparam int unsigned HI_W  = PIN_CNT - MIX_DED,
  localparam int unsigned IDX_W = $clog2(PIN_CNT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PIN_CNT-1:0] pinN,
  input  logic               nmiN,
  input  ctrlStrb_t          strb,
  output logic [PIN_CNT-1:0] srcPending,
  output logic               topValid,
  output logic [IDX_W-1:0]   topSrc,
  output logic               vecValid,
  output logic [PIN_CNT-1:0] vecNum,
  output logic               nmiPending
);

  logic [PIN_CNT:0]   syncQ;
  logic [PIN_CNT:0]   prevQ;
  logic [PIN_CNT:0]   fallBits;
  logic [PIN_CNT-1:0] pinS;
  logic [PIN_CNT-1:0] latchQ, latchNext, pendNext;
  logic               nmiQ, nmiNext;
  logic [PIN_CNT-1:0] vecRaw;
  logic               vecHas;
  logic               anyPend;
  logic [IDX_W-1:0]   topIdx;

  extIrqSync #(.WIDTH(PIN_CNT + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({nmiN, pinN}),
    .dout (syncQ)
  );

  assign pinS     = syncQ[PIN_CNT-1:0];
  assign fallBits = prevQ & ~syncQ;

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= '1;
    else       prevQ <= syncQ;
  end

  // edge latches and level sources
  assign latchNext = strb.edgeMask & ((latchQ & ~strb.latchClr) | fallBits[PIN_CNT-1:0]);
  assign pendNext  = (strb.dedMask & ~strb.edgeMask & ~pinS) | latchNext;
  assign nmiNext   = (nmiQ & ~strb.nmiClr) | fallBits[PIN_CNT];

  // vector forming
  always_comb begin
    case (strb.vecSel)
      VEC_FULL: begin
        vecRaw = ~pinS;
        vecHas = |(~pinS);
      end
      VEC_SPLIT: begin
        vecRaw = {~pinS[HI_W-1:0], MIX_LOW_PAT};
        vecHas = |(~pinS[HI_W-1:0]);
      end
      default: begin
        vecRaw = '0;
        vecHas = 1'b0;
      end
    endcase
  end

  extIrqPrio #(.N(PIN_CNT)) u_prio (
    .req    (pendNext),
    .anyReq (anyPend),
    .topIdx (topIdx)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ     <= '0;
      nmiQ       <= 1'b0;
      srcPending <= '0;
      topValid   <= 1'b0;
      topSrc     <= '0;
      vecValid   <= 1'b0;
      vecNum     <= '0;
    end else begin
      latchQ     <= latchNext;
      nmiQ       <= nmiNext;
      srcPending <= pendNext;
      topValid   <= anyPend & ~nmiNext;
      topSrc     <= topIdx;
      vecValid   <= vecHas & ~nmiNext;
      vecNum     <= vecHas ? vecRaw : '0;
    end
  end

  assign nmiPending = nmiQ;

  // R5
  prio_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    topValid |-> ((srcPending >> topSrc) == PIN_CNT'(1)));

  // R9
  nmi_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    nmiPending |-> (!topValid && !vecValid));

  // R6
  vec_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (vecNum != '0));

  // R6
  exp_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.vecSel == VEC_FULL) |=> (srcPending == '0));

  // R7
  split_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.vecSel == VEC_SPLIT) |=> (!vecValid || vecNum[MIX_DED-1:0] == MIX_LOW_PAT));

  // R8
  nmi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nmiPending) |-> $past(strb.nmiClr));

  for (genvar i = 0; i < PIN_CNT; i++) begin : g_latchChk
    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(latchQ[i]) |-> $past(strb.latchClr[i] || !strb.edgeMask[i]));
  end

endmodule

// File: rtl/extIrqDecoder.sv
module extIrqDecoder
  import extIrqPkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIX_DED     = 3,
  parameter logic [MIX_DED-1:0] MIX_LOW_PAT = 3'b010
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [PIN_CNT-1:0]         pinN,
  input  logic                       nmiN,
  input  logic [1:0]                 modeSel,
  input  logic [PIN_CNT-1:0]         edgeSel,
  input  logic [PIN_CNT-1:0]         srcEnable,
  input  logic [PIN_CNT-1:0]         ackSrc,
  input  logic                       ackNmi,
  output logic [PIN_CNT-1:0]         srcPending,
  output logic                       topValid,
  output logic [$clog2(PIN_CNT)-1:0] topSrc,
  output logic                       vecValid,
  output logic [PIN_CNT-1:0]         vecNum,
  output logic                       nmiPending
);

  ctrlStrb_t strb;

  extIrqCtrl #(.MIX_DED(MIX_DED)) u_ctrl (
    .modeSel   (modeSel),
    .edgeSel   (edgeSel),
    .srcEnable (srcEnable),
    .ackSrc    (ackSrc),
    .ackNmi    (ackNmi),
    .strb      (strb)
  );

  extIrqDatapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .MIX_DED     (MIX_DED),
    .MIX_LOW_PAT (MIX_LOW_PAT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .pinN       (pinN),
    .nmiN       (nmiN),
    .strb       (strb),
    .srcPending (srcPending),
    .topValid   (topValid),
    .topSrc     (topSrc),
    .vecValid   (vecValid),
    .vecNum     (vecNum),
    .nmiPending (nmiPending)
  );

endmodule

// File: tb/extIrqDecoder_tb_top.sv
module extIrqDecoder_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] pinN;
  logic       nmiN;
  logic [1:0] modeSel;
  logic [7:0] edgeSel, srcEnable, ackSrc;
  logic       ackNmi;
  logic [7:0] srcPending;
  logic       topValid;
  logic [2:0] topSrc;
  logic       vecValid;
  logic [7:0] vecNum;
  logic       nmiPending;

  always #10 clk = ~clk;

  extIrqDecoder dut_i (
    .clk(clk), .rstN(rstN), .pinN(pinN), .nmiN(nmiN), .modeSel(modeSel),
    .edgeSel(edgeSel), .srcEnable(srcEnable), .ackSrc(ackSrc), .ackNmi(ackNmi),
    .srcPending(srcPending), .topValid(topValid), .topSrc(topSrc),
    .vecValid(vecValid), .vecNum(vecNum), .nmiPending(nmiPending)
  );

  typedef struct packed {
    logic [7:0] src;
    logic       tv;
    logic [2:0] ts;
    logic       vv;
    logic [7:0] vn;
    logic       nmi;
  } obs_t;

  obs_t  expQ[$];
  string tagQ[$];
  event  sampleEv;
  int    vecCnt  = 0;
  int    missCnt = 0;
  bit    doneFlag = 1'b0;

  // driver side: push expected item, wake monitor
  task automatic expectNow(string tag, logic [7:0] src, logic tv, logic [2:0] ts,
                           logic vv, logic [7:0] vn, logic nmi);
    obs_t e;
    e.src = src; e.tv = tv; e.ts = ts; e.vv = vv; e.vn = vn; e.nmi = nmi;
    expQ.push_back(e);
    tagQ.push_back(tag);
    ->sampleEv;
    #1;
  endtask

  // monitor side: pop and compare
  initial begin : monitor
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        obs_t  e;
        obs_t  a;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        a.src = srcPending; a.tv = topValid; a.ts = topSrc;
        a.vv = vecValid; a.vn = vecNum; a.nmi = nmiPending;
        vecCnt++;
        if (a !== e) begin
          missCnt++;
          $display("FAIL %s: actual src=%h tv=%b ts=%0d vv=%b vn=%h nmi=%b expected src=%h tv=%b ts=%0d vv=%b vn=%h nmi=%b",
                   t, a.src, a.tv, a.ts, a.vv, a.vn, a.nmi, e.src, e.tv, e.ts, e.vv, e.vn, e.nmi);
        end
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulsePin(int idx);
    pinN[idx] = 1'b0;
    idle(1);
    pinN[idx] = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!doneFlag) begin
      missCnt++;
      $display("FAIL watchdog: actual run still active expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
      $finish;
    end
  end

  initial begin : driver
    rstN = 1'b0; pinN = 8'hFF; nmiN = 1'b1; modeSel = 2'd0;
    edgeSel = 8'h00; srcEnable = 8'hFF; ackSrc = 8'h00; ackNmi = 1'b0;
    idle(4);
    rstN = 1'b1;
    idle(3);
    expectNow("R1 reset state", 8'h00, 0, 0, 0, 8'h00, 0);

    // R2 level source and latency
    pinN = 8'hFB;
    idle(2);
    expectNow("R2 not before third edge", 8'h00, 0, 0, 0, 8'h00, 0);
    idle(1);
    expectNow("R2 level pin2 pending", 8'h04, 1, 2, 0, 8'h00, 0);

    // R5 highest index wins
    pinN = 8'hBB;
    idle(3);
    expectNow("R5 pins 6 and 2", 8'h44, 1, 6, 0, 8'h00, 0);
    pinN = 8'hFF;
    idle(3);
    expectNow("R2 level released", 8'h00, 0, 0, 0, 8'h00, 0);

    // R3 edge latch and acknowledge
    edgeSel = 8'h08;
    idle(1);
    pulsePin(3);
    idle(3);
    expectNow("R3 edge latched", 8'h08, 1, 3, 0, 8'h00, 0);
    idle(4);
    expectNow("R3 edge held", 8'h08, 1, 3, 0, 8'h00, 0);
    ackSrc = 8'h08;
    idle(1);
    ackSrc = 8'h00;
    expectNow("R3 ack clears", 8'h00, 0, 0, 0, 8'h00, 0);

    // R4 disabled sources
    srcEnable = 8'hF7;
    idle(1);
    pulsePin(3);
    idle(3);
    expectNow("R4 disabled edge ignored", 8'h00, 0, 0, 0, 8'h00, 0);
    srcEnable = 8'hFF;
    idle(1);
    expectNow("R4 edge not kept", 8'h00, 0, 0, 0, 8'h00, 0);
    edgeSel = 8'h00;
    srcEnable = 8'hFD;
    pinN = 8'hFD;
    idle(3);
    expectNow("R4 disabled level ignored", 8'h00, 0, 0, 0, 8'h00, 0);
    pinN = 8'hFF;
    srcEnable = 8'hFF;
    idle(3);

    // R6 expanded vector
    modeSel = 2'd1;
    pinN = 8'hA5;
    idle(3);
    expectNow("R6 vector 5A", 8'h00, 0, 0, 1, 8'h5A, 0);
    pinN = 8'hFE;
    idle(3);
    expectNow("R6 vector 01", 8'h00, 0, 0, 1, 8'h01, 0);
    pinN = 8'hFF;
    idle(3);
    expectNow("R6 all high no request", 8'h00, 0, 0, 0, 8'h00, 0);

    // R7 mixed mode
    modeSel = 2'd2;
    pinN = 8'h6C;
    idle(3);
    expectNow("R7 pin7 and vector 9A", 8'h80, 1, 7, 1, 8'h9A, 0);
    pinN = 8'hDF;
    idle(3);
    expectNow("R7 pin5 no vector", 8'h20, 1, 5, 0, 8'h00, 0);
    pinN = 8'hFB;
    idle(3);
    expectNow("R7 pin2 is vector bit", 8'h00, 0, 0, 1, 8'h22, 0);
    pinN = 8'hFF;
    idle(3);

    // R10 mode switch drops latched edge
    modeSel = 2'd0;
    edgeSel = 8'h04;
    idle(1);
    pulsePin(2);
    idle(3);
    expectNow("R10 edge latched before switch", 8'h04, 1, 2, 0, 8'h00, 0);
    modeSel = 2'd1;
    idle(1);
    expectNow("R10 dropped in expanded", 8'h00, 0, 0, 0, 8'h00, 0);
    modeSel = 2'd0;
    idle(1);
    expectNow("R10 not restored", 8'h00, 0, 0, 0, 8'h00, 0);

    // R11 spare mode acts as dedicated
    edgeSel = 8'h00;
    modeSel = 2'd3;
    pinN = 8'hFE;
    idle(3);
    expectNow("R11 spare mode level pin0", 8'h01, 1, 0, 0, 8'h00, 0);
    pinN = 8'hFF;
    modeSel = 2'd0;
    idle(3);

    // R8 and R9 non-maskable
    pinN = 8'hBF;
    idle(3);
    expectNow("R9 pin6 before nmi", 8'h40, 1, 6, 0, 8'h00, 0);
    nmiN = 1'b0;
    idle(3);
    expectNow("R9 nmi hides top", 8'h40, 0, 6, 0, 8'h00, 1);
    idle(3);
    expectNow("R8 nmi held", 8'h40, 0, 6, 0, 8'h00, 1);
    ackNmi = 1'b1;
    idle(1);
    ackNmi = 1'b0;
    expectNow("R8 nmi acked", 8'h40, 1, 6, 0, 8'h00, 0);
    idle(3);
    expectNow("R8 low nmi no retrigger", 8'h40, 1, 6, 0, 8'h00, 0);
    nmiN = 1'b1;
    pinN = 8'hFF;
    modeSel = 2'd1;
    idle(3);
    pinN = 8'hF0;
    nmiN = 1'b0;
    idle(3);
    expectNow("R9 nmi hides vector", 8'h00, 0, 0, 0, 8'h0F, 1);
    ackNmi = 1'b1;
    idle(1);
    ackNmi = 1'b0;
    expectNow("R9 vector after ack", 8'h00, 0, 0, 1, 8'h0F, 0);

    doneFlag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

endmodule